// File: doc/BRIEF.md
# Digital Black-Level Clamp Loop

This block is a feedback controller that keeps the black level of a sampled image-sensor pixel stream at a programmable target. A window input marks the shielded black pixels of each line. While the window is open, every valid pixel is compared against the target and the signed error is summed. When the window closes, the mean error is approximated by an arithmetic shift, scaled by a loop gain shift, and subtracted from an offset code. That code drives a correction DAC at the converter input, which closes the loop.

The target is an 8-bit code. With a 12-bit converter one code step is one converter LSB. With a 10-bit converter one code step is a quarter LSB, so the target reaches 63.75 LSB in fractional steps. A line counter lets the loop correct on every line or only on every Nth line. When the loop is turned off, the DAC code is held at a fixed value set by the target code, so the target register acts as a static offset.

Top module: `blackClampLoop`

## Requirements
- R1: While `rst` is sampled high, `dacCode` becomes mid-scale (2^(DAC_W-1), 512 by default) on the next clock and the line counter becomes 0. The first window completed after reset, before any `lineStart`, is therefore an update window.
- R2: Only pixels that have `clampWin` and `pixValid` high in the same cycle add to the window's error sum. Pixels outside the window, and window cycles with `pixValid` low, have no effect on `dacCode`.
- R3: The per-pixel error is pixData*2^F - levelCode, with F = 0 for a 12-bit converter and F = 2 for a 10-bit converter. A 10-bit target code of 5 therefore means 1.25 LSB.
- R4: A window ends in the first cycle `clampWin` is sampled low after being high. On that clock edge, if the loop is on and the line is an update line, `dacCode` becomes `dacCode - (sum >>> (floor(log2(n)) + gainShift))`, where sum is the signed error sum and n is the valid pixel count. The shift rounds toward minus infinity. The new value is visible after that edge. While the loop is on, `dacCode` changes at no other edge.
- R5: The updated code saturates at 0 and at 2^DAC_W-1 and never wraps.
- R6: A window that contains no valid pixel leaves `dacCode` unchanged.
- R7: Each `lineStart` sets the line counter to 0 if it is at or above `updInterval`; otherwise the counter increments by 1. Only windows that end while the counter is 0 apply an update. With `updInterval` = 2, the third and sixth lines after reset update.
- R8: While `loopEn` is low, `dacCode` is loaded on each clock with min(2^(DAC_W-1) + levelCode, 2^DAC_W-1), and windows do not change it. When `loopEn` returns high, the loop continues from that held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixData | input | PIX_W | Digitized pixel from the converter |
| pixValid | input | 1 | pixData holds a sample this cycle |
| clampWin | input | 1 | High during the shielded black pixels |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| levelCode | input | 8 | Black target code, step 1 LSB (12-bit) or 0.25 LSB (10-bit) |
| loopEn | input | 1 | 1 runs the loop, 0 holds the static offset |
| updInterval | input | IV_W | Number of lines skipped between updates |
| gainShift | input | GS_W | Extra right shift applied to the mean error |
| dacCode | output | DAC_W | Offset code for the correction DAC |

## Verification
An update is due on the clock edge that first samples `clampWin` low after a window, so the bench lowers the window on a falling edge and reads `dacCode` on the next falling edge, one full cycle later. A static offset is due one edge after `loopEn` or `levelCode` changes and is read the same way. Line-skip behaviour is checked after every line, including the lines that must not update, and the fractional target is checked by comparing a 10-bit instance and a 12-bit instance on the same stimulus. Every expected code is worked out by hand from the update formula and written into the vector table or the directed tests.

// File: rtl/blackClampPkg.sv
package blackClampPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic accEn;       // add this pixel's error
    logic accClr;      // window closed: clear sum and count
    logic applyUpd;    // window closed on an update line with loop on
    logic loadStatic;  // loop off: hold static offset
  } clampCtl_t;

  // Index of the highest set bit; 0 for an input of 0
  function automatic int floorLog2(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/blackClampCtl.sv
module blackClampCtl
  import blackClampPkg::*;
#(
  parameter int IV_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clampWin,
  input  logic            pixValid,
  input  logic            lineStart,
  input  logic            loopEn,
  input  logic [IV_W-1:0] updInterval,
  output clampCtl_t       ctl
);

  logic            winDly;
  logic [IV_W-1:0] lineCnt;
  logic            winEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      winDly  <= 1'b0;
      lineCnt <= '0;
    end else begin
      winDly <= clampWin;
      if (lineStart) begin
        lineCnt <= (lineCnt >= updInterval) ? '0 : lineCnt + IV_W'(1);
      end
    end
  end

  assign winEnd = winDly & ~clampWin;

  always_comb begin
    ctl.accEn      = clampWin & pixValid;
    ctl.accClr     = winEnd;
    ctl.applyUpd   = winEnd & loopEn & (lineCnt == '0);
    ctl.loadStatic = ~loopEn;
  end

endmodule

// File: rtl/blackClampDp.sv
module blackClampDp
  import blackClampPkg::*;
#(
  parameter int PIX_W = 12,
  parameter int DAC_W = 10,
  parameter int CNT_W = 12,
  parameter int GS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixData,
  input  logic [7:0]       levelCode,
  input  logic [GS_W-1:0]  gainShift,
  input  clampCtl_t        ctl,
  output logic [DAC_W-1:0] dacCode
);

  // Target fraction bits: narrower converters see the code in sub-LSB steps
  localparam int FRAC  = (PIX_W < 12) ? (12 - PIX_W) : 0;
  localparam int MAG_W = ((PIX_W + FRAC) > 8) ? (PIX_W + FRAC) : 8;
  localparam int ERR_W = MAG_W + 2;
  localparam int ACC_W = ERR_W + CNT_W;
  localparam int SUM_W = ACC_W + 1;
  localparam int SH_W  = $clog2(CNT_W + (1 << GS_W)) + 1;
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] TOP = '1;

  logic signed [ERR_W-1:0] pixScaled;
  logic signed [ERR_W-1:0] target;
  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] errSum;
  logic [CNT_W-1:0]        pixCount;
  logic                    cntFull;
  logic [SH_W-1:0]         shiftAmt;
  logic signed [ACC_W-1:0] delta;
  logic signed [SUM_W-1:0] trial;
  logic [DAC_W-1:0]        loopNext;
  logic [DAC_W:0]          staticSum;
  logic [DAC_W-1:0]        staticVal;

  // Per-pixel error in target units
  always_comb begin
    pixScaled = $signed(ERR_W'(pixData)) <<< FRAC;
    target    = $signed(ERR_W'(levelCode));
    err       = pixScaled - target;
  end

  assign cntFull = &pixCount;

  // Window accumulator; stops adding once the count saturates
  always_ff @(posedge clk) begin
    if (rst || ctl.accClr) begin
      errSum   <= '0;
      pixCount <= '0;
    end else if (ctl.accEn && !cntFull) begin
      errSum   <= errSum + ACC_W'(err);
      pixCount <= pixCount + CNT_W'(1);
    end
  end

  // Mean by shift, loop gain by further shift, then saturating subtract
  always_comb begin
    shiftAmt = SH_W'(floorLog2(32'(pixCount))) + SH_W'(gainShift);
    delta    = errSum >>> shiftAmt;
    trial    = $signed(SUM_W'(dacCode)) - SUM_W'(delta);
    if (trial < 0) begin
      loopNext = '0;
    end else if (trial > $signed(SUM_W'(TOP))) begin
      loopNext = TOP;
    end else begin
      loopNext = trial[DAC_W-1:0];
    end
  end

  // Static offset while the loop is off
  always_comb begin
    staticSum = {1'b0, MID} + (DAC_W+1)'(levelCode);
    staticVal = (staticSum > {1'b0, TOP}) ? TOP : staticSum[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dacCode <= MID;
    end else if (ctl.loadStatic) begin
      dacCode <= staticVal;
    end else if (ctl.applyUpd && (pixCount != '0)) begin
      dacCode <= loopNext;
    end
  end

endmodule

// File: rtl/blackClampLoop.sv
module blackClampLoop
  import blackClampPkg::*;
#(
  parameter int PIX_W = 12,
  parameter int DAC_W = 10,
  parameter int CNT_W = 12,
  parameter int IV_W  = 4,
  parameter int GS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixData,
  input  logic             pixValid,
  input  logic             clampWin,
  input  logic             lineStart,
  input  logic [7:0]       levelCode,
  input  logic             loopEn,
  input  logic [IV_W-1:0]  updInterval,
  input  logic [GS_W-1:0]  gainShift,
  output logic [DAC_W-1:0] dacCode
);

  clampCtl_t ctl;

  blackClampCtl #(.IV_W(IV_W)) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .clampWin   (clampWin),
    .pixValid   (pixValid),
    .lineStart  (lineStart),
    .loopEn     (loopEn),
    .updInterval(updInterval),
    .ctl        (ctl)
  );

  blackClampDp #(
    .PIX_W(PIX_W),
    .DAC_W(DAC_W),
    .CNT_W(CNT_W),
    .GS_W (GS_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .pixData  (pixData),
    .levelCode(levelCode),
    .gainShift(gainShift),
    .ctl      (ctl),
    .dacCode  (dacCode)
  );

endmodule

// File: rtl/blackClampChk.sv
module blackClampChk #(
  parameter int DAC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             clampWin,
  input logic             pixValid,
  input logic             loopEn,
  input logic [7:0]       levelCode,
  input logic [DAC_W-1:0] dacCode
);

  localparam int MIDV = 1 << (DAC_W - 1);
  localparam int TOPV = (1 << DAC_W) - 1;

  logic winPrev;
  logic sawValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      winPrev  <= 1'b0;
      sawValid <= 1'b0;
    end else begin
      winPrev <= clampWin;
      if (winPrev && !clampWin) sawValid <= 1'b0;
      else if (clampWin && pixValid) sawValid <= 1'b1;
    end
  end

  AST_RESET_MID: assert property (@(posedge clk)
    rst |=> (int'(dacCode) == MIDV)); // R1

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (loopEn && !(winPrev && !clampWin)) |=> $stable(dacCode)); // R4

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (loopEn && winPrev && !clampWin && !sawValid) |=> $stable(dacCode)); // R6

  AST_STATIC_OFFSET: assert property (@(posedge clk) disable iff (rst)
    !loopEn |=> (int'(dacCode) ==
      (((MIDV + int'($past(levelCode))) > TOPV) ? TOPV : (MIDV + int'($past(levelCode)))))); // R8

endmodule

bind blackClampLoop blackClampChk #(.DAC_W(DAC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clampWin (clampWin),
  .pixValid (pixValid),
  .loopEn   (loopEn),
  .levelCode(levelCode),
  .dacCode  (dacCode)
);

// File: tb/blackClampLoop_tb_top.sv
module blackClampLoop_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pixData;
  logic        pixValid;
  logic        clampWin;
  logic        lineStart;
  logic [7:0]  levelCode;
  logic        loopEn;
  logic [3:0]  updInterval;
  logic [2:0]  gainShift;
  logic [9:0]  dacCode;
  logic [9:0]  dacCode10;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  blackClampLoop dut_i (
    .clk(clk), .rst(rst), .pixData(pixData), .pixValid(pixValid),
    .clampWin(clampWin), .lineStart(lineStart), .levelCode(levelCode),
    .loopEn(loopEn), .updInterval(updInterval), .gainShift(gainShift),
    .dacCode(dacCode)
  );

  blackClampLoop #(.PIX_W(10)) dut10_i (
    .clk(clk), .rst(rst), .pixData(pixData[9:0]), .pixValid(pixValid),
    .clampWin(clampWin), .lineStart(lineStart), .levelCode(levelCode),
    .loopEn(loopEn), .updInterval(updInterval), .gainShift(gainShift),
    .dacCode(dacCode10)
  );

  // Vectors start from mid-scale 512, update every line, loop on
  localparam int NV = 14;
  localparam int vLevel [NV] = '{64, 64, 64, 64, 100, 0, 255, 255, 255, 255, 255, 255, 255, 64};
  localparam int vN     [NV] = '{20, 20, 16, 3, 8, 4, 4, 4, 4, 4, 4, 0, 8, 1};
  localparam int vPix   [NV] = '{64, 74, 60, 67, 90, 4095, 0, 0, 0, 0, 0, 0, 1023, 70};
  localparam int vGain  [NV] = '{0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  localparam int vExp   [NV] = '{512, 500, 504, 500, 503, 0, 255, 510, 765, 1020, 1023, 1023, 639, 633};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doLine();
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
  endtask

  // Window with n valid pixels, each followed by an invalid garbage cycle
  task automatic runWin(input int n, input int pix);
    clampWin = 1'b1;
    for (int i = 0; i < n; i++) begin
      pixValid = 1'b1;
      pixData  = 12'(pix);
      @(negedge clk);
      pixValid = 1'b0;
      pixData  = 12'hFFF;
      @(negedge clk);
    end
    @(negedge clk);
    clampWin = 1'b0;
    @(negedge clk);  // update happened on the edge just passed
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset mid-scale 12-bit", int'(dacCode), 512);
    check("R1 reset mid-scale 10-bit", int'(dacCode10), 512);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pixData = '0; pixValid = 1'b0; clampWin = 1'b0;
    lineStart = 1'b0; levelCode = '0; loopEn = 1'b1;
    updInterval = '0; gainShift = '0;
    @(negedge clk);
    doReset();

    // Table walk: R4 update, R5 saturation, R6 empty window
    for (int i = 0; i < NV; i++) begin
      string tag;
      levelCode = 8'(vLevel[i]);
      gainShift = 3'(vGain[i]);
      doLine();
      runWin(vN[i], vPix[i]);
      if (vN[i] == 0) tag = "R6 empty window";
      else if (vExp[i] == 0 || vExp[i] == 1023) tag = "R5 saturation";
      else tag = "R4 update";
      check($sformatf("%s vector %0d", tag, i), int'(dacCode), vExp[i]);
    end

    // R2: pixels outside the window are ignored
    levelCode = 8'd64; gainShift = '0;
    clampWin = 1'b0; pixValid = 1'b1; pixData = 12'hFFF;
    repeat (10) @(negedge clk);
    pixValid = 1'b0;
    check("R2 outside pixels no change", int'(dacCode), 633);
    doLine();
    runWin(4, 64);
    check("R2 outside pixels not summed", int'(dacCode), 633);

    // R7: update every third line
    doReset();
    updInterval = 4'd2; levelCode = 8'd64;
    for (int k = 1; k <= 6; k++) begin
      doLine();
      runWin(16, 74);
      check($sformatf("R7 interval line %0d", k), int'(dacCode), 512 - 10 * (k / 3));
    end

    // R8: loop off holds static offset, resumes from it
    updInterval = '0;
    loopEn = 1'b0; levelCode = 8'd100;
    @(negedge clk);
    check("R8 static offset", int'(dacCode), 612);
    doLine();
    runWin(8, 4095);
    check("R8 window ignored when off", int'(dacCode), 612);
    levelCode = 8'd7;
    @(negedge clk);
    check("R8 static follows level", int'(dacCode), 519);
    loopEn = 1'b1; levelCode = 8'd64;
    @(negedge clk);
    check("R8 held on re-enable", int'(dacCode), 519);
    doLine();
    runWin(16, 74);
    check("R8 loop resumes", int'(dacCode), 509);

    // R3: quarter-LSB target on the 10-bit instance
    doReset();
    levelCode = 8'd5;
    doLine();
    runWin(4, 1);
    check("R3 10-bit target 1.25 LSB", int'(dacCode10), 513);
    check("R3 12-bit target 5 LSB", int'(dacCode), 516);
    levelCode = 8'd2;
    doLine();
    runWin(4, 1);
    check("R3 10-bit target 0.5 LSB", int'(dacCode10), 511);
    check("R3 12-bit target 2 LSB", int'(dacCode), 517);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule